// File: doc/BRIEF.md
# Long-Press Reset Pulse Timer

This block turns a push-button into a deliberate system reset. The active-low button input is synchronized and watched. Only a press held for a long, fixed number of clock cycles produces a reset. Shorter presses leave no trace. When the hold interval completes, the block drives its active-low output low for a fixed pulse width and ignores the button while it does so. The output is meant to enable the pull-down of an open-drain reset line.

After the pulse ends, the block will not start another one until the button has been let go. A button that stays stuck down therefore yields exactly one reset. A mode input selects a factory-test behaviour in which the pulse starts at once on a press, with no hold delay. The block takes the mode input only during reset or while it is idle with the button up. Board logic usually ties the mode input to a fixed level.

Top module: `long_press_reset`

## Requirements
- R1: While `rst_n` is low and right after it returns high, `rst_out_n` is 1, the block is idle and its counter is zero.
- R2: `btn_n` passes through two synchronizer flops before the control logic sees it. In normal mode, with `btn_n` driven low just after a falling clock edge and held, `rst_out_n` goes low after the (HOLD_CYCLES+2)-th rising edge.
- R3: A press that the control logic samples low for fewer than HOLD_CYCLES consecutive cycles never changes `rst_out_n`. On release the hold count clears, so the next press needs the full interval again.
- R4: A press sampled low for exactly HOLD_CYCLES consecutive cycles is enough to start the pulse, even if the button is released right after.
- R5: Once `rst_out_n` goes low it stays low for exactly PULSE_CYCLES clock cycles and then returns to 1, whatever the button does during the pulse.
- R6: After a pulse, `rst_out_n` stays 1 for as long as the button remains held. A new pulse needs a release followed by a new press.
- R7: In test mode (mode register = 1), `rst_out_n` goes low after the 3rd rising edge following a press: two synchronizer stages plus one control cycle, with no hold delay.
- R8: The mode register loads `test_mode` only during reset or when the block is idle with the synchronized button high. A change of `test_mode` during a press, a pulse or the wait for release has no effect on that press.
- R9: In test mode the pulse lasts PULSE_CYCLES cycles, and a held button does not start a second pulse until it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_n | input | 1 | Push-button, active low, asynchronous to `clk` |
| test_mode | input | 1 | 1 selects zero-delay test behaviour; loaded only when idle with the button up |
| rst_out_n | output | 1 | Registered active-low reset pulse; 0 enables the open-drain pull-down |

## Verification
On every cycle, the checker confirms four things. An early release returns the block to idle with a cleared count. A full hold count starts the pulse. The pulse keeps going until its count is used up and then stops. A held button in the post-pulse wait never re-triggers. The checker also confirms that the mode register moves only while the block is idle with the button up. Only the bench scenarios show the timing as seen from the pins: the synchronizer latency, the boundary between HOLD_CYCLES-1 and HOLD_CYCLES low samples, and the exact pulse width with a release in the middle of the pulse. They also show that a mode change in the middle of a press has no effect, and how the block behaves once test mode is in force.

// File: rtl/lpr_pkg.sv
// Shared types for the long-press reset timer.
// Assumes: nothing beyond IEEE 1800-2017.
package lpr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PULSE = 2'd2,
        ST_WAIT  = 2'd3
    } lpr_state_t;
endpackage

// File: rtl/lpr_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes: din changes slowly compared with clk; RST_VAL is the idle level.
module lpr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the input level through the flop chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/lpr_counter.sv
// Shared interval counter: load to one, step up, or clear.
// Assumes: the controller never asks for a load and a step in the same cycle.
module lpr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_one,
    input  logic         step,
    output logic [W-1:0] count
);
    // Counter update; it clears whenever it is neither loaded nor stepped.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (load_one) count <= W'(1);
        else if (step)     count <= count + W'(1);
        else               count <= '0;
    end
endmodule

// File: rtl/lpr_ctrl.sv
// Controller for the long-press timer: state machine, mode register and
// registered output.
// Assumes: btn_s is already synchronized; HOLD_CYCLES >= 2, PULSE_CYCLES >= 1.
module lpr_ctrl
    import lpr_pkg::*;
#(
    parameter int HOLD_CYCLES  = 16,
    parameter int PULSE_CYCLES = 8,
    parameter int W            = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         btn_s,
    input  logic         mode_in,
    input  logic [W-1:0] count,
    output lpr_state_t   state,
    output logic         mode_q,
    output logic         load_one,
    output logic         step,
    output logic         out_n
);
    localparam logic [W-1:0] HOLD_LAST  = W'(HOLD_CYCLES - 1);
    localparam logic [W-1:0] PULSE_LAST = W'(PULSE_CYCLES);

    lpr_state_t nxt;

    // Next-state and counter-command decode.
    always_comb begin
        nxt      = state;
        load_one = 1'b0;
        step     = 1'b0;
        case (state)
            ST_IDLE: begin
                if (!btn_s) begin
                    load_one = 1'b1;
                    nxt      = mode_q ? ST_PULSE : ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (btn_s) begin
                    nxt = ST_IDLE;
                end else if (count == HOLD_LAST) begin
                    load_one = 1'b1;
                    nxt      = ST_PULSE;
                end else begin
                    step = 1'b1;
                end
            end
            ST_PULSE: begin
                if (count == PULSE_LAST) nxt  = ST_WAIT;
                else                     step = 1'b1;
            end
            ST_WAIT: begin
                if (btn_s) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register and glitch-free registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            out_n <= 1'b1;
        end else begin
            state <= nxt;
            out_n <= (nxt != ST_PULSE);
        end
    end

    // Mode register: loads in reset or when idle with the button up.
    always_ff @(posedge clk) begin
        if (!rst_n || (state == ST_IDLE && btn_s)) mode_q <= mode_in;
    end
endmodule

// File: rtl/long_press_reset.sv
// Top of the long-press reset timer.
// Assumes: btn_n is asynchronous to clk; test_mode changes only while the
// button is up; HOLD_CYCLES >= 2 and PULSE_CYCLES >= 1.
module long_press_reset
    import lpr_pkg::*;
#(
    parameter int HOLD_CYCLES  = 245760,
    parameter int PULSE_CYCLES = 13107,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    input  logic test_mode,
    output logic rst_out_n
);
    localparam int MAX_COUNT = (HOLD_CYCLES > PULSE_CYCLES) ? HOLD_CYCLES : PULSE_CYCLES;
    localparam int CNT_W     = $clog2(MAX_COUNT + 1);

    logic             btn_s;
    logic             mode_q;
    logic             load_one;
    logic             step;
    logic [CNT_W-1:0] cnt;
    lpr_state_t       state;

    lpr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(btn_n), .dout(btn_s)
    );

    lpr_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_one(load_one), .step(step), .count(cnt)
    );

    lpr_ctrl #(
        .HOLD_CYCLES(HOLD_CYCLES), .PULSE_CYCLES(PULSE_CYCLES), .W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .btn_s(btn_s), .mode_in(test_mode),
        .count(cnt), .state(state), .mode_q(mode_q),
        .load_one(load_one), .step(step), .out_n(rst_out_n)
    );
endmodule

// File: rtl/lpr_checker.sv
// Cycle-by-cycle property checks for long_press_reset, bound to the top.
// Assumes: the parameters match those of the bound instance.
module lpr_checker
    import lpr_pkg::*;
#(
    parameter int HOLD_CYCLES  = 16,
    parameter int PULSE_CYCLES = 8,
    parameter int CNT_W        = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             btn_s,
    input logic             mode_q,
    input lpr_state_t       state,
    input logic [CNT_W-1:0] cnt,
    input logic             rst_out_n
);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYCLES - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYCLES);

    assert_short_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && btn_s) |=> (state == ST_IDLE && cnt == '0 && rst_out_n));

    assert_hold_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !btn_s && cnt == HOLD_LAST) |=> !rst_out_n);

    assert_pulse_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_out_n && cnt != PULSE_LAST) |=> !rst_out_n);

    assert_pulse_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_out_n && cnt == PULSE_LAST) |=> rst_out_n);

    assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !btn_s) |=> (rst_out_n && state == ST_WAIT));

    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_IDLE && btn_s) |=> $stable(mode_q));
endmodule

bind long_press_reset lpr_checker #(
    .HOLD_CYCLES(HOLD_CYCLES), .PULSE_CYCLES(PULSE_CYCLES), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .btn_s(btn_s), .mode_q(mode_q),
    .state(state), .cnt(cnt), .rst_out_n(rst_out_n)
);

// File: tb/sim_long_press_reset.sv
module sim_long_press_reset;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 20;
    localparam int PULSE      = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_n = 1'b1;
    logic test_mode = 1'b0;
    logic rst_out_n;
    int   n_checks = 0;
    int   n_fail = 0;

    long_press_reset #(.HOLD_CYCLES(HOLD), .PULSE_CYCLES(PULSE)) u0 (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n),
        .test_mode(test_mode), .rst_out_n(rst_out_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Output must stay high on n falling edges; the count of low samples is checked.
    task automatic stay_high(int n, string req);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_out_n !== 1'b1) lows++;
        end
        check(req, lows, 0);
    endtask

    // Press at the current falling edge; the first low sample is expected at
    // falling edge 'lat'. The button is released at falling edge 'rel' (0 = keep held).
    task automatic run_press(int lat, int rel, string req_delay, string req_width);
        int early = 0;
        int width = 0;
        btn_n = 1'b0;
        for (int n = 1; n <= lat + PULSE; n++) begin
            @(negedge clk);
            if (n < lat && rst_out_n !== 1'b1) early++;
            if (n >= lat && rst_out_n === 1'b0) width++;
            if (n == rel) btn_n = 1'b1;
        end
        check(req_delay, early, 0);
        check(req_width, width, PULSE);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 out high in reset", rst_out_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out high after reset", rst_out_n, 1);
    endtask

    task automatic t_short();
        btn_n = 1'b0;
        repeat (HOLD - 1) @(negedge clk);
        btn_n = 1'b1;
        stay_high(2 * HOLD, "R3 short press no pulse");
        // Count must have cleared: a full press again needs the whole interval.
        run_press(HOLD + 2, 0, "R3 full delay after short press", "R5 width");
        btn_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_boundary();
        run_press(HOLD + 2, HOLD, "R4 exact-hold press delay", "R4 exact-hold press pulses");
        stay_high(HOLD, "R4 single pulse after release");
    endtask

    task automatic t_long_held();
        run_press(HOLD + 2, 0, "R2 sync latency plus hold", "R5 width with button held");
        @(negedge clk);
        check("R5 pulse ends", rst_out_n, 1);
        stay_high(3 * HOLD, "R6 held button no retrigger");
        btn_n = 1'b1;
        repeat (4) @(negedge clk);
        run_press(HOLD + 2, HOLD + 4, "R6 re-arm after release", "R5 width release mid-pulse");
        stay_high(HOLD, "R5 no extra pulse");
    endtask

    task automatic t_mode_ignored();
        btn_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        test_mode = 1'b1;
        check("R8 mode change mid-press ignored", rst_out_n, 1);
        stay_high(HOLD - 3, "R8 hold delay kept after mode change");
        begin
            int lows = 0;
            repeat (PULSE) begin
                @(negedge clk);
                if (rst_out_n === 1'b0) lows++;
            end
            check("R8 normal pulse despite mode change", lows, PULSE);
        end
        btn_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_test_mode();
        run_press(3, 0, "R7 test mode immediate", "R9 test pulse width");
        stay_high(2 * HOLD, "R9 test mode no retrigger");
        test_mode = 1'b0;
        stay_high(2, "R8 mode change while held ignored");
        btn_n = 1'b1;
        repeat (4) @(negedge clk);
        run_press(HOLD + 2, 0, "R8 normal mode restored", "R5 width normal");
        btn_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        repeat (3) @(negedge clk);
        t_short();
        t_boundary();
        t_long_held();
        t_mode_ignored();
        t_test_mode();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule